// File: doc/BRIEF.md
# SPI Master with Queued Word Streaming

This block is a single-mode SPI master. Software-side logic writes 16-bit words into a 4-deep transmit queue. Each word is loaded whole into a 16-bit shift register and sent MSB first. The bits that come back on the data-in line are shifted into the same register. When a word completes, the register contents are written into a 4-deep receive queue. Both queues report how many words they hold. Each queue also has an active-low run control: while that control is 0, the queue's pointers stay cleared.

The serial clock idles low. Data is launched on its falling edge and sampled on its rising edge. Each half period lasts a programmable number of system cycles, with a minimum of two.

The select line decides how words group into transactions. If the next word is already queued when the current one ends, and the inter-word delay is zero, select stays low and the clock runs on without a break. This lets frames longer than 16 bits go out as one transaction. A nonzero delay always releases select between words.

A character length of 8 bits sends only the upper byte of each queued word. In that case the received word holds the original low byte in its upper half and the received byte in its lower half.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, ss_n is 1, sclk is 0, both queue counts are 0 and both overflow flags are 0.
- R2: With H = max(cfg_half, 2), the serial clock spends H system cycles low and H system cycles high for each bit, idling low. Inside one transaction, consecutive rising edges are exactly 2H cycles apart. mosi changes only while sclk is low.
- R3: A transaction starting from idle drives ss_n low exactly H cycles before its first rising sclk edge.
- R4: ss_n returns high exactly H cycles after the rising edge of the last bit, when the transaction does not continue.
- R5: With cfg_gap = 0 and the next word already queued when a word ends, ss_n stays low and the next word's first rising edge follows the previous last rising edge by exactly 2H cycles.
- R6: With cfg_gap = G > 0, ss_n is released between words. With the next word already queued, ss_n stays high for exactly G*2H+1 system cycles.
- R7: With cfg_len16 = 1, all 16 bits of a word are sent MSB first. The received word is the 16 bits read on miso, first bit in bit 15.
- R8: With cfg_len16 = 0, only bits 15..8 of the queued word are sent, MSB first (8 clock pulses). The received word is {queued word[7:0], 8 received bits}.
- R9: tx_count and rx_count give the number of words held, from 0 to 4. A write strobe is reflected in the count at the next clock edge. A word is taken from the transmit queue when it starts.
- R10: A write to a full transmit queue, or a completed word arriving at a full receive queue, is dropped and sets that queue's sticky overflow flag.
- R11: While tx_run or rx_run is 0, that queue's count and overflow flag are held at 0 and its writes are ignored. After the control returns to 1, the queue operates again starting from empty.
- R12: rx_count rises by one on the same clock edge as the last bit's rising sclk edge, even when ss_n stays low for a following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len16 | input | 1 | 1: 16-bit characters, 0: 8-bit characters |
| cfg_half | input | HALFW | Serial clock half period in system cycles (values below 2 act as 2) |
| cfg_gap | input | GAPW | Inter-word delay in serial clock periods; 0 allows select continuation |
| tx_run | input | 1 | Transmit queue run control, 0 holds it cleared |
| tx_wr | input | 1 | Transmit queue write strobe |
| tx_data | input | 16 | Word to queue, left-justified for 8-bit characters |
| tx_count | output | CW | Words held in the transmit queue |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_run | input | 1 | Receive queue run control, 0 holds it cleared |
| rx_rd | input | 1 | Receive queue pop strobe |
| rx_data | output | 16 | Oldest received word (show-ahead) |
| rx_count | output | CW | Words held in the receive queue |
| rx_ovf | output | 1 | Sticky receive overflow |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench observes the serial lines on each falling system clock edge and times every transition as it happens:
- ss_n falls H cycles before the first rising sclk edge.
- Rising edges within one select window are 2H cycles apart.
- ss_n rises H cycles after the last rising edge.
- Between delayed words, ss_n stays high for G*2H+1 cycles.

Receive counts move on the same system edge that raises sclk for the last bit, so the bench records rx_count at the observation point just after that rise. Queue counts and flags change one edge after a strobe. Stimulus is driven 1 ns after a rising edge, and those values are read one full cycle later.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LOW,
    ENG_HIGH,
    ENG_GAP
  } eng_state_t;

  localparam int unsigned MIN_HALF = 2;

  // Effective half period of the serial clock, in system cycles.
  function automatic logic [15:0] half_cycles(input logic [15:0] cfg);
    return (cfg < 16'(MIN_HALF)) ? 16'(MIN_HALF) : cfg;
  endfunction

  // Idle time between words, in system cycles: gap serial periods.
  function automatic logic [31:0] gap_cycles(input logic [15:0] gap,
                                             input logic [15:0] half);
    return 32'(gap) * 32'(half) * 32'd2;
  endfunction

  // Index of the final bit of a character.
  function automatic logic [4:0] final_bit(input logic len16);
    return len16 ? 5'd15 : 5'd7;
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = run && wr && !full;
  assign do_rd = run && rd && !empty;
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (!run) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr && full) ovf <= 1'b1;
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr && full && !rd) |=> (!run || (ovf && count == $past(count))));

  assert_hold_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0 && !ovf));

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_half,
  input  logic [31:0] cfg_gap_cyc,
  input  logic        len16,
  input  logic        tx_avail,
  input  logic [15:0] tx_word,
  output logic        tx_pop,
  input  logic        miso,
  output logic        rx_push,
  output logic [15:0] rx_word,
  output logic        sclk,
  output logic        mosi,
  output logic        ss_n
);

  eng_state_t  state;
  logic [15:0] cnt;
  logic [31:0] gcnt;
  logic [4:0]  bitn;
  logic [15:0] sr;

  // Named internal events, shared by the logic and the assertions.
  logic half_end, last, rise_evt, fall_evt, chain, start;

  assign half_end = (cnt >= cfg_half - 16'd1);
  assign last     = (bitn == final_bit(len16));
  assign rise_evt = (state == ENG_LOW)  && half_end;
  assign fall_evt = (state == ENG_HIGH) && half_end;
  assign chain    = fall_evt && last && tx_avail && (cfg_gap_cyc == 32'd0);
  assign start    = (state == ENG_IDLE) && tx_avail;
  assign tx_pop   = start || chain;
  assign rx_push  = rise_evt && last;
  assign rx_word  = {sr[14:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      gcnt  <= '0;
      bitn  <= '0;
      sr    <= '0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      ss_n  <= 1'b1;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (tx_avail) begin
            sr    <= tx_word;
            mosi  <= tx_word[15];
            ss_n  <= 1'b0;
            bitn  <= '0;
            cnt   <= '0;
            state <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          if (half_end) begin
            sclk  <= 1'b1;
            sr    <= rx_word;
            cnt   <= '0;
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        ENG_HIGH: begin
          if (half_end) begin
            sclk <= 1'b0;
            cnt  <= '0;
            if (!last) begin
              bitn  <= bitn + 5'd1;
              mosi  <= sr[15];
              state <= ENG_LOW;
            end else if (chain) begin
              sr    <= tx_word;
              mosi  <= tx_word[15];
              bitn  <= '0;
              state <= ENG_LOW;
            end else begin
              ss_n <= 1'b1;
              mosi <= 1'b0;
              gcnt <= '0;
              state <= (cfg_gap_cyc == 32'd0) ? ENG_IDLE : ENG_GAP;
            end
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        default: begin
          if (gcnt >= cfg_gap_cyc - 32'd1) state <= ENG_IDLE;
          else gcnt <= gcnt + 32'd1;
        end
      endcase
    end
  end

  assert_sclk_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);

  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_push_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> $rose(sclk));

  assert_release_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> !sclk);

  assert_chain_keeps_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> !ss_n);

  assert_bit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bitn <= 5'd15);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int HALFW = 8,
  parameter int GAPW  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_len16,
  input  logic [HALFW-1:0] cfg_half,
  input  logic [GAPW-1:0]  cfg_gap,
  input  logic             tx_run,
  input  logic             tx_wr,
  input  logic [15:0]      tx_data,
  output logic [CW-1:0]    tx_count,
  output logic             tx_ovf,
  input  logic             rx_run,
  input  logic             rx_rd,
  output logic [15:0]      rx_data,
  output logic [CW-1:0]    rx_count,
  output logic             rx_ovf,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n
);

  logic [15:0] half_eff;
  logic [31:0] gap_eff;
  logic [15:0] tx_head, rx_word;
  logic        tx_full, tx_empty, tx_pop;
  logic        rx_full, rx_empty, rx_push;

  assign half_eff = half_cycles(16'(cfg_half));
  assign gap_eff  = gap_cycles(16'(cfg_gap), half_eff);

  spi_word_fifo #(.W(16), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .run(tx_run),
    .wr(tx_wr), .wdata(tx_data), .rd(tx_pop), .rdata(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty), .ovf(tx_ovf)
  );

  spi_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cfg_half(half_eff), .cfg_gap_cyc(gap_eff), .len16(cfg_len16),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .miso(miso), .rx_push(rx_push), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  spi_word_fifo #(.W(16), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .run(rx_run),
    .wr(rx_push), .wdata(rx_word), .rd(rx_rd), .rdata(rx_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .ovf(rx_ovf)
  );

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_count != '0);

  assert_tx_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_run && tx_wr && tx_full) |=> (tx_ovf || !tx_run));

  assert_rx_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_run && rx_push && rx_full) |=> (rx_ovf || !rx_run));

  assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !rx_push) |=> rx_count == '0);

endmodule

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_len16 = 1'b1;
  logic [7:0]  cfg_half = 8'd2;
  logic [7:0]  cfg_gap = 8'd0;
  logic        tx_run = 1'b1, tx_wr = 1'b0, rx_run = 1'b1, rx_rd = 1'b0;
  logic [15:0] tx_data = '0;
  logic [2:0]  tx_count, rx_count;
  logic        tx_ovf, rx_ovf, sclk, mosi, ss_n;
  logic [15:0] rx_data;
  logic        miso = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  spi_fifo_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len16(cfg_len16), .cfg_half(cfg_half),
    .cfg_gap(cfg_gap), .tx_run(tx_run), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_count(tx_count), .tx_ovf(tx_ovf), .rx_run(rx_run), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_count(rx_count), .rx_ovf(rx_ovf),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_tests = 0, n_fail = 0;

  // Line monitor and slave model, evaluated on falling system edges.
  int cyc = 0, exp_h = 2;
  int rise_cnt, ss_falls, t_ssfall, t_ssrise, t_last, ss_high_len;
  int lead_bad, tail_bad, gap_bad, rx_at16, ss_at16;
  bit have_prev, prev_sclk = 1'b0, prev_ss = 1'b1;
  logic [31:0] slave_pat, mosi_log;

  always @(negedge clk) begin
    cyc++;
    if (prev_ss && !ss_n) begin
      ss_falls++;
      if (t_ssrise > 0) ss_high_len = cyc - t_ssrise;
      t_ssfall = cyc;
      have_prev = 1'b0;
    end
    if (!prev_ss && ss_n) begin
      t_ssrise = cyc;
      if (cyc - t_last != exp_h) tail_bad++;
    end
    if (!prev_sclk && sclk) begin
      if (have_prev) begin
        if (cyc - t_last != 2 * exp_h) gap_bad++;
      end else if (cyc - t_ssfall != exp_h) lead_bad++;
      have_prev = 1'b1;
      t_last = cyc;
      mosi_log = {mosi_log[30:0], mosi};
      rise_cnt++;
      if (rise_cnt == 16) begin
        rx_at16 = int'(rx_count);
        ss_at16 = int'(ss_n);
      end
    end
    miso = (rise_cnt < 32) ? slave_pat[31 - rise_cnt] : 1'b0;
    prev_sclk = sclk;
    prev_ss = ss_n;
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [31:0] pat);
    rise_cnt = 0; ss_falls = 0; t_ssrise = 0; t_last = 0; ss_high_len = 0;
    lead_bad = 0; tail_bad = 0; gap_bad = 0; rx_at16 = -1; ss_at16 = -1;
    mosi_log = '0; slave_pat = pat; have_prev = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    tx_wr = 1'b1; tx_data = d; tick(1); tx_wr = 1'b0;
  endtask

  task automatic pop();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int guard = 0;
    while (int'(rx_count) < n && guard < 20000) begin tick(1); guard++; end
    while (!ss_n && guard < 20000) begin tick(1); guard++; end
    tick(2);
  endtask

  // {len16, half[3:0], tx word, slave word, expected rx word}
  localparam logic [52:0] VEC [0:5] = '{
    {1'b1, 4'd2, 16'hA53C, 16'h5AC3, 16'h5AC3},
    {1'b1, 4'd3, 16'h8001, 16'hFFFF, 16'hFFFF},
    {1'b0, 4'd2, 16'h12AB, 16'hC700, 16'hABC7},
    {1'b0, 4'd4, 16'hF00F, 16'h3C00, 16'h0F3C},
    {1'b1, 4'd0, 16'h0000, 16'h0001, 16'h0001},
    {1'b1, 4'd5, 16'hFFFF, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_mon(32'h0);
    tick(3);
    // R1 reset state
    check("R1 ss_n", ss_n, 1); check("R1 sclk", sclk, 0);
    check("R1 counts", {tx_count, rx_count}, 0);
    check("R1 ovf", {tx_ovf, rx_ovf}, 0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < 6; i++) begin
      logic [52:0] v;
      v = VEC[i];
      cfg_len16 = v[52]; cfg_half = {4'd0, v[51:48]}; cfg_gap = 8'd0;
      exp_h = (v[51:48] < 4'd2) ? 2 : int'(v[51:48]);
      clear_mon({v[31:16], 16'h0});
      push(v[47:32]);
      wait_done(1);
      if (v[52]) begin
        check("R7 rx word", rx_data, v[15:0]);
        check("R7 mosi bits", mosi_log[15:0], v[47:32]);
        check("R7 pulses", rise_cnt, 16);
      end else begin
        check("R8 rx word", rx_data, v[15:0]);
        check("R8 mosi bits", mosi_log[7:0], v[47:40]);
        check("R8 pulses", rise_cnt, 8);
      end
      check("R2 period", gap_bad, 0);
      check("R3 lead", lead_bad, 0);
      check("R4 tail", tail_bad, 0);
      check("R9 rx count", rx_count, 1);
      pop();
      check("R9 rx count after pop", rx_count, 0);
    end

    // R5 / R12: back-to-back words with zero delay form one transaction
    cfg_len16 = 1'b1; cfg_half = 8'd2; cfg_gap = 8'd0; exp_h = 2;
    clear_mon(32'h1234_9ABC);
    push(16'hC3A5); push(16'h0FF0);
    wait_done(2);
    check("R5 one select window", ss_falls, 1);
    check("R5 continuous clock", gap_bad, 0);
    check("R5 pulses", rise_cnt, 32);
    check("R5 mosi stream", mosi_log, 32'hC3A5_0FF0);
    check("R12 count at last bit", rx_at16, 1);
    check("R12 select still low", ss_at16, 0);
    check("R7 first rx", rx_data, 16'h1234);
    pop();
    check("R7 second rx", rx_data, 16'h9ABC);
    pop();

    // R6: nonzero delay releases select between words
    cfg_gap = 8'd1;
    clear_mon(32'h0);
    push(16'h5555); push(16'hAAAA);
    wait_done(2);
    check("R6 two select windows", ss_falls, 2);
    check("R6 high time", ss_high_len, 1 * 2 * 2 + 1);
    check("R6 mosi stream", mosi_log, 32'h5555_AAAA);
    pop(); pop();
    cfg_gap = 8'd0;

    // R9 / R10: overflow of both queues
    cfg_half = 8'd5; exp_h = 5;
    clear_mon(32'h0);
    for (int k = 0; k < 6; k++) begin
      tx_wr = 1'b1; tx_data = 16'(16'h1000 + k); tick(1);
    end
    tx_wr = 1'b0;
    check("R9 tx count full", tx_count, 4);
    check("R10 tx overflow", tx_ovf, 1);
    wait_done(4);
    check("R10 dropped word not sent", rise_cnt, 80);
    check("R9 rx count full", rx_count, 4);
    check("R10 rx overflow", rx_ovf, 1);

    // R11: run controls clear and hold the queues
    tx_run = 1'b0; tick(1);
    check("R11 tx cleared", {tx_count, tx_ovf}, 0);
    clear_mon(32'h0);
    push(16'hBEEF); tick(30);
    check("R11 tx write ignored", tx_count, 0);
    check("R11 nothing sent", rise_cnt, 0);
    tx_run = 1'b1;
    rx_run = 1'b0; tick(1);
    check("R11 rx cleared", {rx_count, rx_ovf}, 0);
    rx_run = 1'b1; tick(1);
    clear_mon(32'h6C6C_0000);
    push(16'h0F0F);
    wait_done(1);
    check("R11 resume from empty", rx_count, 1);
    check("R11 resumed data", rx_data, 16'h6C6C);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule